// File: doc/BRIEF.md
# Dual Fixed-Interval Pulse Generator

This block produces two independent trains of periodic pulses derived from the nominal tick of a time counter. Every tick represents a fixed number of nanoseconds, given on the `tick_ns` input. Each channel holds a down-counter that starts at its programmed interval and drops by `tick_ns` on every tick. A tick that would take the counter below zero is a firing: the counter reloads from the interval input, and the channel sets its sticky event flag and requests an output pulse.

The interval is programmed in nanoseconds as the wanted period minus one tick. That value equals prescaler × tick period × divisor − tick period, where the divisor is the output-clock frequency divided by the wanted pulse frequency. With a 10 ns tick, 999,999,990 gives one pulse per second and 99,990 gives one pulse every 100 µs.

The output pulse is aligned to a strobe marking the edges of the prescaled output clock. It lasts exactly one period of that clock. An interval change is picked up at the next reload, so a period that is in progress is never cut short. One channel is normally set up for one pulse per second.

Top module: `periodic_pulse_gen`

## Requirements
- R1: While `rst` is high, and in the cycle after it is sampled high, every `pulse_o` and `evt_o` bit is 0.
- R2: When `enable[c]` rises, the counter loads `interval[c]`, and a tick sampled in that same cycle is ignored. Counting ticks from the next cycle, the first firing happens on tick number floor(I/T)+1, where I is the interval and T is `tick_ns`.
- R3: After a firing, the next firing happens exactly floor(I/T)+1 ticks later. With T=10, I=99,990 fires every 10,000 ticks and I=999,999,990 fires every 100,000,000 ticks.
- R4: A firing arms the channel's pulse. On the next cycle with `oclk_stb` high (the firing cycle itself included), `pulse_o[c]` goes high. It goes low on the following `oclk_stb` unless another firing is pending. Each change appears on the clock edge that samples the strobe.
- R5: `evt_o[c]` goes to 1 on the same clock edge that samples the firing tick, and only while the channel is enabled.
- R6: `evt_o[c]` stays 1 until a cycle with `evt_clr[c]`=1 and no firing. A firing in the same cycle as the clear leaves the flag at 1.
- R7: While `enable[c]` is 0, `pulse_o[c]` is 0 from the next edge onward, and ticks neither fire nor set `evt_o[c]`.
- R8: A new `interval[c]` written mid-period does not shorten or stretch the current period. It sets the length of the periods that follow the next reload.
- R9: The two channels count, fire, flag and clear independently of each other.
- R10: Disabling and then re-enabling a channel throws away any partial count and starts a full interval again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Nominal tick strobe of the time counter |
| tick_ns | input | SW (8) | Nominal tick period in ns, at least 1 |
| oclk_stb | input | 1 | One-cycle strobe at each prescaled output-clock period |
| interval | input | NCH×IW (2×32) | Per-channel interval in ns (period minus one tick) |
| enable | input | NCH (2) | Per-channel enable |
| evt_clr | input | NCH (2) | Per-channel write-one-to-clear of the event flag |
| pulse_o | output | NCH (2) | Per-channel periodic pulse |
| evt_o | output | NCH (2) | Per-channel sticky event flag |

## Verification
The bench measures tick counts between firings for random intervals and tick periods. It also checks the 100 µs setting exactly, which would catch an off-by-one design that fires one tick early or late, or that drops the remainder of I/T. Directed cases cover the following:
- Pulse width against a slow strobe: a design that pulses for a single system cycle fails this case.
- A clear that coincides with a firing: a design that gives the clear priority loses that event.
- Disable followed by re-enable: a design that keeps the stale partial count fires early.
- An interval change in mid-period: a design that reloads at once changes the current period.

// File: rtl/ppg_pkg.sv
package ppg_pkg;
  // Per-channel status leaving the counter stage.
  typedef struct packed {
    logic armed;
    logic fire;
  } ctr_stat_t;

  // Per-channel registered outputs of the shaping stage.
  typedef struct packed {
    logic pulse;
    logic evt;
  } chan_out_t;
endpackage

// File: rtl/ppg_down_counter.sv
module ppg_down_counter
  import ppg_pkg::*;
#(
  parameter int IW = 32,
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          tick,
  input  logic [SW-1:0] step,
  input  logic [IW-1:0] reload_val,
  output ctr_stat_t     stat
);
  localparam int XW = (IW > SW) ? IW : SW;

  logic [IW-1:0] remain;
  logic          armed;
  logic [XW-1:0] remain_x, step_x;
  logic          underflow;

  assign remain_x  = XW'(remain);
  assign step_x    = XW'(step);
  assign underflow = remain_x < step_x;

  assign stat.fire  = en & armed & tick & underflow;
  assign stat.armed = armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain <= '0;
      armed  <= 1'b0;
    end else if (!en) begin
      armed <= 1'b0;
    end else if (!armed) begin
      remain <= reload_val;
      armed  <= 1'b1;
    end else if (tick) begin
      if (underflow) remain <= reload_val;
      else           remain <= IW'(remain_x - step_x);
    end
  end
endmodule

// File: rtl/ppg_shaper.sv
module ppg_shaper
  import ppg_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      en,
  input  ctr_stat_t stat,
  input  logic      oclk_stb,
  input  logic      clr,
  output chan_out_t out
);
  logic pend, pulse_q, evt_q;
  logic live;

  assign live      = en & stat.armed;
  assign out.pulse = pulse_q;
  assign out.evt   = evt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend    <= 1'b0;
      pulse_q <= 1'b0;
    end else if (!live) begin
      pend    <= 1'b0;
      pulse_q <= 1'b0;
    end else if (oclk_stb) begin
      pulse_q <= pend | stat.fire;
      pend    <= 1'b0;
    end else begin
      pend <= pend | stat.fire;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            evt_q <= 1'b0;
    else if (stat.fire) evt_q <= 1'b1;
    else if (clr)       evt_q <= 1'b0;
  end
endmodule

// File: rtl/periodic_pulse_gen.sv
module periodic_pulse_gen
  import ppg_pkg::*;
#(
  parameter int NCH = 2,
  parameter int IW  = 32,
  parameter int SW  = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    tick,
  input  logic [SW-1:0]           tick_ns,
  input  logic                    oclk_stb,
  input  logic [NCH-1:0][IW-1:0]  interval,
  input  logic [NCH-1:0]          enable,
  input  logic [NCH-1:0]          evt_clr,
  output logic [NCH-1:0]          pulse_o,
  output logic [NCH-1:0]          evt_o
);
  for (genvar g = 0; g < NCH; g++) begin : g_chan
    ctr_stat_t stat;
    chan_out_t cout;

    ppg_down_counter #(.IW(IW), .SW(SW)) u_cnt (
      .clk        (clk),
      .rst        (rst),
      .en         (enable[g]),
      .tick       (tick),
      .step       (tick_ns),
      .reload_val (interval[g]),
      .stat       (stat)
    );

    ppg_shaper u_shp (
      .clk      (clk),
      .rst      (rst),
      .en       (enable[g]),
      .stat     (stat),
      .oclk_stb (oclk_stb),
      .clr      (evt_clr[g]),
      .out      (cout)
    );

    assign pulse_o[g] = cout.pulse;
    assign evt_o[g]   = cout.evt;
  end
endmodule

// File: rtl/periodic_pulse_gen_chk.sv
module periodic_pulse_gen_chk #(
  parameter int NCH = 2
) (
  input logic           clk,
  input logic           rst,
  input logic           oclk_stb,
  input logic [NCH-1:0] enable,
  input logic [NCH-1:0] evt_clr,
  input logic [NCH-1:0] pulse_o,
  input logic [NCH-1:0] evt_o
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (pulse_o == '0 && evt_o == '0));

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    assert_disable_low_R7: assert property (@(posedge clk) disable iff (rst)
      !enable[c] |=> !pulse_o[c]);

    assert_pulse_on_strobe_R4: assert property (@(posedge clk) disable iff (rst)
      (enable[c] && !oclk_stb) |=> $stable(pulse_o[c]));

    assert_evt_needs_enable_R5: assert property (@(posedge clk) disable iff (rst)
      $rose(evt_o[c]) |-> $past(enable[c]));

    assert_evt_sticky_R6: assert property (@(posedge clk) disable iff (rst)
      (evt_o[c] && !evt_clr[c]) |=> evt_o[c]);
  end
endmodule

bind periodic_pulse_gen periodic_pulse_gen_chk #(.NCH(NCH)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .oclk_stb (oclk_stb),
  .enable   (enable),
  .evt_clr  (evt_clr),
  .pulse_o  (pulse_o),
  .evt_o    (evt_o)
);

// File: tb/periodic_pulse_gen_test.sv
module periodic_pulse_gen_test;
  localparam int NCH = 2;
  localparam int IW  = 32;
  localparam int SW  = 8;

  logic                   clk = 1'b0;
  logic                   rst = 1'b1;
  logic                   tick = 1'b0;
  logic [SW-1:0]          tick_ns = 8'd10;
  logic                   oclk_stb = 1'b1;
  logic [NCH-1:0][IW-1:0] interval = '0;
  logic [NCH-1:0]         enable = '0;
  logic [NCH-1:0]         evt_clr = '0;
  logic [NCH-1:0]         pulse_o, evt_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  periodic_pulse_gen #(.NCH(NCH), .IW(IW), .SW(SW)) uut (
    .clk(clk), .rst(rst), .tick(tick), .tick_ns(tick_ns), .oclk_stb(oclk_stb),
    .interval(interval), .enable(enable), .evt_clr(evt_clr),
    .pulse_o(pulse_o), .evt_o(evt_o)
  );

  function automatic int exp_ticks(input longint iv, input int t);
    return int'(iv / t) + 1;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_evt(input int ch);
    evt_clr[ch] = 1'b1; cyc(1); evt_clr[ch] = 1'b0;
  endtask

  task automatic start_ch(input int ch);
    enable[ch] = 1'b1; cyc(1); clear_evt(ch);
  endtask

  // Apply ticks until evt_o[ch] is seen; gap = max idle cycles between ticks.
  task automatic run_until(input int ch, input int limit, input int gap, output int n);
    n = 0;
    while (n < limit) begin
      tick = 1'b1; cyc(1); tick = 1'b0; n++;
      if (evt_o[ch]) break;
      if (gap > 0) cyc($urandom_range(gap, 0));
    end
  endtask

  initial begin
    int n;
    void'($urandom(32'h1588));
    cyc(3);
    rst = 1'b0; cyc(1);
    chk(pulse_o == '0 && evt_o == '0, "R1 reset outputs", {pulse_o, evt_o}, 0);

    // R3: 100 us setting with a 10 ns tick
    tick_ns = 8'd10; interval[0] = 32'd99_990;
    start_ch(0);
    run_until(0, 20000, 0, n);
    chk(n == 10000, "R2 first period 99990", n, 10000);
    clear_evt(0);
    run_until(0, 20000, 0, n);
    chk(n == 10000, "R3 steady period 99990", n, 10000);
    enable[0] = 1'b0; cyc(2);

    // R2/R3 random intervals and tick periods
    for (int it = 0; it < 20; it++) begin
      int iv, t, e;
      t  = $urandom_range(20, 1);
      iv = $urandom_range(300, 0);
      if (it == 0) begin t = 10; iv = 9; end
      if (it == 1) begin t = 10; iv = 10; end
      tick_ns = 8'(t); interval[0] = 32'(iv);
      e = exp_ticks(iv, t);
      start_ch(0);
      run_until(0, 1000, 2, n);
      chk(n == e, "R2 random first period", n, e);
      clear_evt(0);
      run_until(0, 1000, 2, n);
      chk(n == e, "R3 random period", n, e);
      enable[0] = 1'b0; cyc(2);
    end

    // R4 pulse width follows the output-clock strobe
    tick_ns = 8'd10; interval[0] = 32'd0; oclk_stb = 1'b0;
    start_ch(0);
    tick = 1'b1; cyc(1); tick = 1'b0;
    chk(evt_o[0] == 1'b1, "R5 evt on firing edge", evt_o[0], 1);
    chk(pulse_o[0] == 1'b0, "R4 pulse waits for strobe", pulse_o[0], 0);
    cyc(3);
    chk(pulse_o[0] == 1'b0, "R4 pulse still waiting", pulse_o[0], 0);
    oclk_stb = 1'b1; cyc(1); oclk_stb = 1'b0;
    chk(pulse_o[0] == 1'b1, "R4 pulse rises on strobe", pulse_o[0], 1);
    n = 0;
    for (int k = 0; k < 4; k++) begin cyc(1); if (pulse_o[0]) n++; end
    chk(n == 4, "R4 pulse held between strobes", n, 4);
    oclk_stb = 1'b1; cyc(1); oclk_stb = 1'b0;
    chk(pulse_o[0] == 1'b0, "R4 pulse falls on next strobe", pulse_o[0], 0);
    tick = 1'b1; oclk_stb = 1'b1; cyc(1); tick = 1'b0; oclk_stb = 1'b0;
    chk(pulse_o[0] == 1'b1, "R4 firing with strobe same cycle", pulse_o[0], 1);
    cyc(2);
    oclk_stb = 1'b1; cyc(1);
    chk(pulse_o[0] == 1'b0, "R4 pulse ends after one period", pulse_o[0], 0);

    // R6 clear and set-wins
    clear_evt(0);
    chk(evt_o[0] == 1'b0, "R6 clear", evt_o[0], 0);
    cyc(3);
    chk(evt_o[0] == 1'b0, "R6 stays clear", evt_o[0], 0);
    evt_clr[0] = 1'b1; tick = 1'b1; cyc(1); evt_clr[0] = 1'b0; tick = 1'b0;
    chk(evt_o[0] == 1'b1, "R6 firing beats clear", evt_o[0], 1);

    // R7 disable forces pulse low, ticks ignored
    tick = 1'b1; cyc(1); tick = 1'b0;
    chk(pulse_o[0] == 1'b1, "R7 pulse high before disable", pulse_o[0], 1);
    clear_evt(0);
    enable[0] = 1'b0; cyc(1);
    chk(pulse_o[0] == 1'b0, "R7 pulse low after disable", pulse_o[0], 0);
    tick = 1'b1; cyc(4); tick = 1'b0;
    chk(evt_o[0] == 1'b0 && pulse_o[0] == 1'b0, "R7 ticks ignored while disabled",
        {evt_o[0], pulse_o[0]}, 0);

    // R10 re-enable restarts full interval
    interval[0] = 32'd49;
    start_ch(0);
    tick = 1'b1; cyc(3); tick = 1'b0;
    enable[0] = 1'b0; cyc(1);
    start_ch(0);
    run_until(0, 100, 0, n);
    chk(n == 5, "R10 full interval after re-enable", n, 5);
    enable[0] = 1'b0; cyc(1);

    // R8 interval change waits for reload
    interval[0] = 32'd49;
    start_ch(0);
    tick = 1'b1; cyc(2); tick = 1'b0;
    interval[0] = 32'd99;
    run_until(0, 100, 0, n);
    chk(n == 3, "R8 current period unchanged", n, 3);
    clear_evt(0);
    run_until(0, 100, 0, n);
    chk(n == 10, "R8 new interval after reload", n, 10);
    enable[0] = 1'b0; cyc(1);

    // R9 channels independent
    interval[0] = 32'd29; interval[1] = 32'd49;
    enable = 2'b11; cyc(1);
    clear_evt(0); clear_evt(1);
    tick = 1'b1; cyc(3); tick = 1'b0;
    chk(evt_o == 2'b01, "R9 ch0 fires alone", evt_o, 2'b01);
    clear_evt(0);
    tick = 1'b1; cyc(2); tick = 1'b0;
    chk(evt_o == 2'b10, "R9 ch1 fires on its own count", evt_o, 2'b10);
    clear_evt(1);
    chk(evt_o == 2'b00, "R9 clear touches one channel", evt_o, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule